// File: doc/BRIEF.md
# Serial Memory Initialization Sequencer

This block runs the configuration stage for a chain of up to 32 memory devices that share one channel. After a start pulse it produces a fixed series of command descriptors for a serial I/O engine. Each descriptor carries an opcode, a broadcast flag, a device number, a register address and 16 bits of data. Each one is held on the command port until the engine acknowledges it. The sequence does the following, in order:

- gives every device its identifier;
- loads the power-state exit and read-delay timing registers;
- applies a second reset as a set/clear pair to each device;
- seeds both current-control registers at mid-range;
- sends one broadcast power-down exit;
- ends with a per-device SETF command.

After the command phase the block reads each device's timing limits over a parameter lookup port. From these it builds a 64-bit controller configuration word one field per cycle. The row and column timing fields take the largest of the device minimums. The refresh field takes the smallest of the device maximums. The block then raises done. The bit-level serial framing, calibration and read-domain levelling belong to other blocks.

Top module: `chan_init_seq`

## Requirements
- R1: After reset, cmd_valid and done are low and cfg_word is zero.
- R2: Register writes use opcode 1 with the broadcast flag low. Each step sends its write to devices 0 up to N-1 before the next step starts. The steps and their address/data are: power-down exit timing (0x02, 0x0010), second power-down exit timing (0x03, 0x0020), nap exit timing (0x04, 0x0006), read delay at its minimum (0x05, 0x0003), second read delay at its minimum (0x06, 0x0001) and frame timing (0x07, 0x0004). The sequence sends exactly 12·N+1 commands.
- R3: The sequence opens with identifier writes to address 0x01. The data sent to chain position i equals i, for i from 0 to N-1.
- R4: For every device, a set-reset command (opcode 2) is followed at once by a clear-reset command (opcode 3) to the same device. Only then does the set-reset for the next device go out. Address and data are zero.
- R5: Current-control register A (address 0x08) and then register B (address 0x09) are written to every device with (CC_MIN+CC_MAX)/2, which is 0x001F by default.
- R6: Exactly one power-down exit command (opcode 4) is sent. It has the broadcast flag high and device number 0, and it sits between the current-control writes and the SETF commands.
- R7: The sequence ends with a SETF command (opcode 5) to each device in order 0 to N-1.
- R8: A descriptor, once valid, keeps every field unchanged until cmd_ack is sampled high. Exactly one command is consumed per acknowledged cycle.
- R9: The configuration word is laid out as follows:
  - [3:0] holds the read-data offset at its minimum, which is 2.
  - [11:4], [19:12], [27:20], [35:28], [43:36] and [51:44] hold tRAS, tRP, tRC, tRCD, tRR and tPP. Each is the maximum over all devices of the matching 8-bit field of prm_min, where field k sits at prm_min[8k+7:8k].
  - [63:52] holds the minimum over all devices of prm_refmax.
- R10: done goes high N+8 cycles after the edge that accepts the last SETF. done and cfg_word then stay unchanged until the next start. A start pulse while the sequence is busy is ignored, and so is any change of dev_count.
- R11: dev_count is sampled at start. A value of 0 is handled as 1 device, and values above 32 as 32 devices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins the sequence when idle or done |
| dev_count | input | 6 | Number of devices on the chain |
| cmd_valid | output | 1 | Command descriptor valid |
| cmd_ack | input | 1 | Serial engine accepts the descriptor |
| cmd_op | output | 3 | Opcode: 1 write, 2 set-reset, 3 clear-reset, 4 power-down exit, 5 SETF |
| cmd_bcast | output | 1 | Broadcast to all devices |
| cmd_dev | output | 5 | Target device position |
| cmd_addr | output | 8 | Register address |
| cmd_data | output | 16 | Register write data |
| prm_dev | output | 5 | Device whose parameters are being looked up |
| prm_min | input | 48 | Six 8-bit row/column timing minimums of prm_dev |
| prm_refmax | input | 12 | Refresh interval maximum of prm_dev |
| cfg_word | output | 64 | Controller configuration word |
| done | output | 1 | Sequence complete |

## Verification
A descriptor becomes valid on the edge after start or after the previous accepting edge. The bench's serial-engine model therefore samples it at the falling edge, waits a chosen number of cycles and then acknowledges. It logs each command only on the acknowledging cycle and checks that the held fields did not move in between. done is due exactly N+8 edges after the edge that accepts the last SETF: N edges for the parameter scan and 8 for the field writes. The bench counts edges from that accepting edge and compares the count. cfg_word and done are then checked again three cycles later to confirm that they hold.

// File: rtl/chan_init_pkg.sv
package chan_init_pkg;
  localparam int DEV_W    = 5;
  localparam int MAX_DEV  = 32;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 16;
  localparam int OP_W     = 3;
  localparam int TFLD_W   = 8;
  localparam int NUM_TFLD = 6;
  localparam int REF_W    = 12;
  localparam int OFF_W    = 4;
  localparam int CFG_W    = OFF_W + NUM_TFLD * TFLD_W + REF_W;

  typedef enum logic [OP_W-1:0] {
    OP_NONE   = 3'd0,
    OP_WREG   = 3'd1,
    OP_SETR   = 3'd2,
    OP_CLRR   = 3'd3,
    OP_PDEXIT = 3'd4,
    OP_SETF   = 3'd5
  } op_e;

  // order of the enum is the order of the bring-up
  typedef enum logic [3:0] {
    ST_ID, ST_PDX, ST_PDXA, ST_NAPX, ST_RDLY, ST_RDLY2, ST_FRM,
    ST_SETR, ST_CLRR, ST_CCA, ST_CCB, ST_PDEXIT, ST_SETF
  } step_e;

  localparam logic [ADDR_W-1:0] A_DEVID = 8'h01;
  localparam logic [ADDR_W-1:0] A_PDX   = 8'h02;
  localparam logic [ADDR_W-1:0] A_PDXA  = 8'h03;
  localparam logic [ADDR_W-1:0] A_NAPX  = 8'h04;
  localparam logic [ADDR_W-1:0] A_RDLY  = 8'h05;
  localparam logic [ADDR_W-1:0] A_RDLY2 = 8'h06;
  localparam logic [ADDR_W-1:0] A_FRM   = 8'h07;
  localparam logic [ADDR_W-1:0] A_CCA   = 8'h08;
  localparam logic [ADDR_W-1:0] A_CCB   = 8'h09;
endpackage

// File: rtl/chan_init_walk.sv
module chan_init_walk
  import chan_init_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             adv,
  input  logic [DEV_W-1:0] last_dev,
  output step_e            step,
  output logic [DEV_W-1:0] dev,
  output logic             walk_end
);
  step_e            step_q, step_d;
  logic [DEV_W-1:0] dev_q, dev_d;
  logic             upd;

  always_comb begin
    step_d   = step_q;
    dev_d    = dev_q;
    walk_end = 1'b0;
    case (step_q)
      ST_SETR: step_d = ST_CLRR;
      ST_CLRR: begin
        if (dev_q == last_dev) begin
          step_d = ST_CCA;
          dev_d  = '0;
        end else begin
          step_d = ST_SETR;
          dev_d  = dev_q + 1'b1;
        end
      end
      ST_PDEXIT: begin
        step_d = ST_SETF;
        dev_d  = '0;
      end
      default: begin
        if (dev_q == last_dev) begin
          dev_d = '0;
          if (step_q == ST_SETF) walk_end = 1'b1;
          else                   step_d   = step_e'(step_q + 4'd1);
        end else begin
          dev_d = dev_q + 1'b1;
        end
      end
    endcase
  end

  assign upd = restart | (adv & ~walk_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_ID;
      dev_q  <= '0;
    end else if (upd) begin
      step_q <= restart ? ST_ID : step_d;
      dev_q  <= restart ? '0    : dev_d;
    end
  end

  assign step = step_q;
  assign dev  = dev_q;
endmodule

// File: rtl/chan_init_desc.sv
module chan_init_desc
  import chan_init_pkg::*;
#(
  parameter logic [DATA_W-1:0] PDX_VAL   = 16'h0010,
  parameter logic [DATA_W-1:0] PDXA_VAL  = 16'h0020,
  parameter logic [DATA_W-1:0] NAPX_VAL  = 16'h0006,
  parameter logic [DATA_W-1:0] RDLY_MIN  = 16'h0003,
  parameter logic [DATA_W-1:0] RDLY2_MIN = 16'h0001,
  parameter logic [DATA_W-1:0] FRM_VAL   = 16'h0004,
  parameter logic [DATA_W-1:0] CC_MID    = 16'h001F
) (
  input  step_e              step,
  input  logic [DEV_W-1:0]   dev,
  output logic [OP_W-1:0]    op,
  output logic               bcast,
  output logic [DEV_W-1:0]   dev_o,
  output logic [ADDR_W-1:0]  addr,
  output logic [DATA_W-1:0]  data
);
  always_comb begin
    op    = OP_WREG;
    bcast = 1'b0;
    dev_o = dev;
    addr  = '0;
    data  = '0;
    case (step)
      ST_ID:     begin addr = A_DEVID; data = {{(DATA_W-DEV_W){1'b0}}, dev}; end
      ST_PDX:    begin addr = A_PDX;   data = PDX_VAL;   end
      ST_PDXA:   begin addr = A_PDXA;  data = PDXA_VAL;  end
      ST_NAPX:   begin addr = A_NAPX;  data = NAPX_VAL;  end
      ST_RDLY:   begin addr = A_RDLY;  data = RDLY_MIN;  end
      ST_RDLY2:  begin addr = A_RDLY2; data = RDLY2_MIN; end
      ST_FRM:    begin addr = A_FRM;   data = FRM_VAL;   end
      ST_CCA:    begin addr = A_CCA;   data = CC_MID;    end
      ST_CCB:    begin addr = A_CCB;   data = CC_MID;    end
      ST_SETR:   op = OP_SETR;
      ST_CLRR:   op = OP_CLRR;
      ST_PDEXIT: begin op = OP_PDEXIT; bcast = 1'b1; dev_o = '0; end
      ST_SETF:   op = OP_SETF;
      default:   op = OP_NONE;
    endcase
  end
endmodule

// File: rtl/chan_init_agg.sv
module chan_init_agg
  import chan_init_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       en,
  input  logic [NUM_TFLD*TFLD_W-1:0] dmin,
  input  logic [REF_W-1:0]           dref,
  output logic [NUM_TFLD*TFLD_W-1:0] tmax,
  output logic [REF_W-1:0]           rmin
);
  for (genvar g = 0; g < NUM_TFLD; g++) begin : g_fld
    logic [TFLD_W-1:0] q;
    logic              take;
    assign take = en && (dmin[g*TFLD_W +: TFLD_W] > q);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (clr)  q <= '0;
      else if (take) q <= dmin[g*TFLD_W +: TFLD_W];
    end
    assign tmax[g*TFLD_W +: TFLD_W] = q;
  end

  logic [REF_W-1:0] r_q;
  logic             r_take;
  assign r_take = en && (dref < r_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      r_q <= '1;
    else if (clr)    r_q <= '1;
    else if (r_take) r_q <= dref;
  end

  assign rmin = r_q;
endmodule

// File: rtl/chan_init_seq.sv
module chan_init_seq
  import chan_init_pkg::*;
#(
  parameter logic [DATA_W-1:0] PDX_VAL   = 16'h0010,
  parameter logic [DATA_W-1:0] PDXA_VAL  = 16'h0020,
  parameter logic [DATA_W-1:0] NAPX_VAL  = 16'h0006,
  parameter logic [DATA_W-1:0] RDLY_MIN  = 16'h0003,
  parameter logic [DATA_W-1:0] RDLY2_MIN = 16'h0001,
  parameter logic [DATA_W-1:0] FRM_VAL   = 16'h0004,
  parameter int                CC_MIN    = 0,
  parameter int                CC_MAX    = 63,
  parameter logic [OFF_W-1:0]  RDOFF_MIN = 4'd2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [DEV_W:0]             dev_count,
  output logic                       cmd_valid,
  input  logic                       cmd_ack,
  output logic [OP_W-1:0]            cmd_op,
  output logic                       cmd_bcast,
  output logic [DEV_W-1:0]           cmd_dev,
  output logic [ADDR_W-1:0]          cmd_addr,
  output logic [DATA_W-1:0]          cmd_data,
  output logic [DEV_W-1:0]           prm_dev,
  input  logic [NUM_TFLD*TFLD_W-1:0] prm_min,
  input  logic [REF_W-1:0]           prm_refmax,
  output logic [CFG_W-1:0]           cfg_word,
  output logic                       done
);
  localparam logic [DATA_W-1:0] CC_MID = DATA_W'((CC_MIN + CC_MAX) / 2);
  localparam int NUM_FLD = NUM_TFLD + 2;
  localparam int FLD_W   = $clog2(NUM_FLD);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_AGG, S_CFG, S_DONE} st_e;

  st_e                       st_q, st_d;
  logic                      start_ok, adv, walk_end;
  logic [DEV_W-1:0]          last_in, last_q, agg_q, walk_dev;
  logic [FLD_W-1:0]          fld_q;
  logic [CFG_W-1:0]          cfg_q, cfg_nxt;
  logic [NUM_TFLD*TFLD_W-1:0] tmax;
  logic [REF_W-1:0]          rmin;
  step_e                     step;

  assign start_ok  = start && (st_q == S_IDLE || st_q == S_DONE);
  assign cmd_valid = (st_q == S_CMD);
  assign adv       = cmd_valid & cmd_ack;
  assign done      = (st_q == S_DONE);
  assign prm_dev   = agg_q;
  assign cfg_word  = cfg_q;

  // device count clamp to 1..MAX_DEV
  always_comb begin
    if (dev_count == '0)                         last_in = '0;
    else if (dev_count > (DEV_W+1)'(MAX_DEV))    last_in = DEV_W'(MAX_DEV - 1);
    else                                         last_in = DEV_W'(dev_count - 1'b1);
  end

  chan_init_walk u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (start_ok),
    .adv      (adv),
    .last_dev (last_q),
    .step     (step),
    .dev      (walk_dev),
    .walk_end (walk_end)
  );

  chan_init_desc #(
    .PDX_VAL   (PDX_VAL),
    .PDXA_VAL  (PDXA_VAL),
    .NAPX_VAL  (NAPX_VAL),
    .RDLY_MIN  (RDLY_MIN),
    .RDLY2_MIN (RDLY2_MIN),
    .FRM_VAL   (FRM_VAL),
    .CC_MID    (CC_MID)
  ) u_desc (
    .step  (step),
    .dev   (walk_dev),
    .op    (cmd_op),
    .bcast (cmd_bcast),
    .dev_o (cmd_dev),
    .addr  (cmd_addr),
    .data  (cmd_data)
  );

  chan_init_agg u_agg (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start_ok),
    .en    (st_q == S_AGG),
    .dmin  (prm_min),
    .dref  (prm_refmax),
    .tmax  (tmax),
    .rmin  (rmin)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE, S_DONE: if (start_ok) st_d = S_CMD;
      S_CMD:          if (adv && walk_end) st_d = S_AGG;
      S_AGG:          if (agg_q == last_q) st_d = S_CFG;
      S_CFG:          if (fld_q == FLD_W'(NUM_FLD - 1)) st_d = S_DONE;
      default:        st_d = S_IDLE;
    endcase
  end

  always_comb begin
    cfg_nxt = cfg_q;
    if (fld_q == '0)
      cfg_nxt[OFF_W-1:0] = RDOFF_MIN;
    if (fld_q == FLD_W'(NUM_FLD - 1))
      cfg_nxt[CFG_W-1 -: REF_W] = rmin;
    for (int k = 0; k < NUM_TFLD; k++) begin
      if (fld_q == FLD_W'(k + 1))
        cfg_nxt[OFF_W + k*TFLD_W +: TFLD_W] = tmax[k*TFLD_W +: TFLD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        last_q <= '0;
    else if (start_ok) last_q <= last_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              agg_q <= '0;
    else if (start_ok)       agg_q <= '0;
    else if (st_q == S_AGG)  agg_q <= agg_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q <= '0;
      cfg_q <= '0;
    end else if (start_ok) begin
      fld_q <= '0;
      cfg_q <= '0;
    end else if (st_q == S_CFG) begin
      fld_q <= fld_q + 1'b1;
      cfg_q <= cfg_nxt;
    end
  end
endmodule

// File: rtl/chan_init_seq_chk.sv
module chan_init_seq_chk
  import chan_init_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              cmd_valid,
  input logic              cmd_ack,
  input logic [OP_W-1:0]   cmd_op,
  input logic              cmd_bcast,
  input logic [DEV_W-1:0]  cmd_dev,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [DATA_W-1:0] cmd_data,
  input logic [CFG_W-1:0]  cfg_word,
  input logic              done
);
  // R8
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ack |=> cmd_valid && $stable(cmd_op) && $stable(cmd_bcast)
      && $stable(cmd_dev) && $stable(cmd_addr) && $stable(cmd_data));

  // R4
  setr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ack && cmd_op == OP_SETR |=>
      cmd_valid && cmd_op == OP_CLRR && cmd_dev == $past(cmd_dev));

  // R6
  pdexit_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_PDEXIT |-> cmd_bcast && cmd_dev == '0);

  // R2
  wreg_directed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_WREG |-> !cmd_bcast);

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(cfg_word));

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_valid);
endmodule

bind chan_init_seq chan_init_seq_chk u_chk (.*);

// File: tb/chan_init_seq_tb.sv
`timescale 1ns/1ps
module chan_init_seq_tb;
  logic        clk, rst_n, start, cmd_valid, cmd_ack, cmd_bcast, done;
  logic [5:0]  dev_count;
  logic [2:0]  cmd_op;
  logic [4:0]  cmd_dev, prm_dev;
  logic [7:0]  cmd_addr;
  logic [15:0] cmd_data;
  logic [47:0] prm_min;
  logic [11:0] prm_refmax;
  logic [63:0] cfg_word;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int seed = 0, ack_dly = 0, log_n = 0, hold_err = 0, last_ack = 0, ei = 0;
  int lg_op[400], lg_bc[400], lg_dev[400], lg_ad[400], lg_dt[400];

  chan_init_seq u_dut (.*);

  initial begin clk = 0; forever #5 clk = ~clk; end
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] tfield(int d, int k, int s);
    return 8'(5 + ((d * (k + 3) + s * 7 + k * 11) % 23));
  endfunction
  function automatic logic [11:0] rfield(int d, int s);
    return 12'(1000 + ((d * 37 + s * 13) % 500));
  endfunction

  always_comb begin
    for (int k = 0; k < 6; k++) prm_min[k*8 +: 8] = tfield(int'(prm_dev), k, seed);
    prm_refmax = rfield(int'(prm_dev), seed);
  end

  // serial engine model
  initial begin
    int wcnt, pend;
    logic [32:0] prev;
    cmd_ack = 0; wcnt = 0; pend = 0; prev = '0;
    forever begin
      @(negedge clk);
      if (cmd_valid && pend != 0 && {cmd_op, cmd_bcast, cmd_dev, cmd_addr, cmd_data} != prev)
        hold_err++;
      if (cmd_ack) begin
        cmd_ack = 0; pend = 0;
      end else if (cmd_valid) begin
        if (wcnt >= ack_dly) begin
          if (log_n < 400) begin
            lg_op[log_n] = cmd_op; lg_bc[log_n] = cmd_bcast; lg_dev[log_n] = cmd_dev;
            lg_ad[log_n] = cmd_addr; lg_dt[log_n] = cmd_data;
          end
          log_n++;
          cmd_ack = 1; wcnt = 0; pend = 0; last_ack = cyc + 1;
        end else begin
          wcnt++; pend = 1;
          prev = {cmd_op, cmd_bcast, cmd_dev, cmd_addr, cmd_data};
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic expc(input int op, input int bc, input int dv, input int ad, input int dt,
                      input string req);
    if (ei < log_n && ei < 400)
      chk(lg_op[ei] == op && lg_bc[ei] == bc && lg_dev[ei] == dv && lg_ad[ei] == ad
          && lg_dt[ei] == dt, req, $sformatf("command %0d {op,bc,dev,addr,data}", ei),
          {lg_op[ei][7:0], lg_bc[ei][7:0], lg_dev[ei][7:0], lg_ad[ei][7:0], lg_dt[ei][15:0]},
          {op[7:0], bc[7:0], dv[7:0], ad[7:0], dt[15:0]});
    else
      chk(0, req, $sformatf("command %0d missing", ei), 64'(log_n), 64'(ei + 1));
    ei++;
  endtask

  task automatic run_seq(input int n_in, input int n, input int dly, input int sd,
                         input bit poke, input string req);
    int t, done_cyc;
    logic [63:0] exp_cfg;
    logic [7:0] mx;
    logic [11:0] mn;
    seed = sd; ack_dly = dly; log_n = 0; hold_err = 0;
    dev_count = 6'(n_in);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    if (poke) begin
      // R10: start and dev_count change while busy must be ignored
      wait (log_n >= 5);
      @(negedge clk); start = 1; dev_count = 6'd7;
      @(negedge clk); start = 0;
    end
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    done_cyc = cyc;
    // R2 / R11: total command count 12N+1
    chk(log_n == 12 * n + 1, req, "command count", 64'(log_n), 64'(12 * n + 1));
    ei = 0;
    for (int d = 0; d < n; d++) expc(1, 0, d, 8'h01, d, "R3");
    for (int s = 0; s < 6; s++) begin
      int ad, dt;
      case (s)
        0: begin ad = 8'h02; dt = 16'h0010; end
        1: begin ad = 8'h03; dt = 16'h0020; end
        2: begin ad = 8'h04; dt = 16'h0006; end
        3: begin ad = 8'h05; dt = 16'h0003; end
        4: begin ad = 8'h06; dt = 16'h0001; end
        default: begin ad = 8'h07; dt = 16'h0004; end
      endcase
      for (int d = 0; d < n; d++) expc(1, 0, d, ad, dt, "R2");
    end
    for (int d = 0; d < n; d++) begin
      expc(2, 0, d, 0, 0, "R4");
      expc(3, 0, d, 0, 0, "R4");
    end
    for (int d = 0; d < n; d++) expc(1, 0, d, 8'h08, 16'h001F, "R5");
    for (int d = 0; d < n; d++) expc(1, 0, d, 8'h09, 16'h001F, "R5");
    expc(4, 1, 0, 0, 0, "R6");
    for (int d = 0; d < n; d++) expc(5, 0, d, 0, 0, "R7");
    // R8
    chk(hold_err == 0, "R8", "descriptor changed before ack", 64'(hold_err), 64'd0);
    // R10
    chk(done && (done_cyc - last_ack) == n + 8, "R10", "done latency",
        64'(done_cyc - last_ack), 64'(n + 8));
    // R9
    exp_cfg = '0;
    exp_cfg[3:0] = 4'd2;
    for (int k = 0; k < 6; k++) begin
      mx = '0;
      for (int d = 0; d < n; d++) if (tfield(d, k, sd) > mx) mx = tfield(d, k, sd);
      exp_cfg[4 + k*8 +: 8] = mx;
    end
    mn = '1;
    for (int d = 0; d < n; d++) if (rfield(d, sd) < mn) mn = rfield(d, sd);
    exp_cfg[63:52] = mn;
    chk(cfg_word == exp_cfg, "R9", "configuration word", cfg_word, exp_cfg);
    repeat (3) @(negedge clk);
    chk(done && cfg_word == exp_cfg, "R10", "done/cfg_word hold", {63'd0, done}, 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; start = 0; dev_count = 6'd1;
    repeat (3) @(negedge clk);
    // R1
    chk(!cmd_valid && !done && cfg_word == '0, "R1", "reset state {valid,done,cfg}",
        {cmd_valid, done, cfg_word[61:0]}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk(!cmd_valid && !done, "R1", "idle after reset release", {cmd_valid, done}, 64'd0);
    run_seq(3, 3, 0, 1, 0, "R2");
    run_seq(32, 32, 2, 2, 0, "R2");
    run_seq(1, 1, 1, 3, 0, "R2");
    run_seq(4, 4, 1, 4, 1, "R10");
    run_seq(0, 1, 0, 5, 0, "R11");
    run_seq(40, 32, 0, 6, 0, "R11");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule